// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Per-Access Write Policy

This block sits between a CPU load/store port and a word-wide memory port. It keeps a small direct-mapped cache of 32-bit words. Each line is in one of three states: invalid, clean (valid and unmodified) or modified (valid and dirty). The CPU chooses the write policy on every request with a single bit. Copy-back writes stay in the cache. Write-through writes go to memory. A write-through write miss never claims a line.

When a miss lands on a modified line, the old contents first move into a one-line push buffer. The replacement line is then fetched and the CPU is answered. Only after that does the buffer drain to memory, so the victim's write-back is kept off the CPU's critical path. Two maintenance commands share the request port. One drops every line without writing anything back. The other writes a single modified line back and leaves it clean.

CPU and memory addresses are word addresses. Every memory beat is a single word and is held until the memory acknowledges it. A line fill or write-back is a run of single-word beats.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset every line is invalid. The invalidate-all command (op code 1) returns every line to invalid with no memory traffic, even for modified lines. A later read of a formerly modified address fetches the old memory value.
- R2: A read miss on an invalid or clean line issues WORDS memory reads for the line, word 0 first and in ascending order. It returns the requested word and leaves the line clean.
- R3: A read hit returns the cached word with no memory traffic and leaves the line state unchanged.
- R4: A copy-back write miss (cpu_req_wt = 0) fills the line from memory and merges the write word into it. The line becomes modified, and its later eviction writes the merged data back.
- R5: A write-through write miss (cpu_req_wt = 1) performs exactly one memory write and allocates nothing. A later read of that address is a miss.
- R6: A copy-back write hit updates only the cache and makes the line modified.
- R7: A write-through write hit on a clean line writes the word both to memory and to the cache. The line stays clean, so its eviction causes no write-back.
- R8: On a miss to a modified line the order is: all fill reads of the new line, then the CPU response, then WORDS memory writes of the victim at its old address.
- R9: The push-line command (op code 2, line chosen by the index bits of cpu_req_addr) writes a modified line back and leaves it clean. It produces no memory traffic for clean or invalid lines. Its response comes after the write-back.
- R10: A write-through write hit on a modified line updates only the cache and leaves the line modified. No write-through access ever makes a clean or invalid line modified.
- R11: A memory request holds its address, direction and data steady until mem_ack is seen.
- R12: Each accepted request (op code 0 = access) yields exactly one cpu_rsp_valid pulse. After reset cpu_req_ready is high and no memory request is active. No memory request is active while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_op | input | 2 | 0 access, 1 invalidate all, 2 push line |
| cpu_req_we | input | 1 | Access is a write |
| cpu_req_wt | input | 1 | 1 write-through, 0 copy-back |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read data, valid with the pulse for reads |
| mem_req_valid | output | 1 | Memory beat requested |
| mem_req_we | output | 1 | Beat is a write |
| mem_req_addr | output | ADDR_W | Word address of the beat |
| mem_req_wdata | output | DATA_W | Write data of the beat |
| mem_ack | input | 1 | Memory accepts the beat; read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The access path is driven with directed sequences. These cover hit and miss under both policies, against invalid, clean and modified lines, so that a confusion between the three line states shows up as an extra or missing memory beat. A conflicting tag on the same index separates a merged write-back from a plain one, and a victim write-back that overtakes the response shows up as a reordering of the expected beats. A pseudo-random phase then mixes policies, commands and three tags over all indices, with random memory latency. Every memory beat and response is compared in order against a line-state model built from the requirements.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {
    OP_ACCESS  = 2'd0,
    OP_INV_ALL = 2'd1,
    OP_PUSH    = 2'd2,
    OP_RSVD    = 2'd3
  } dc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_PUSH,
    ST_FILL,
    ST_WT,
    ST_DRAIN
  } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 27,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [TAG_W-1:0] wtag,
  input  logic             wvalid,
  input  logic             wdirty,
  input  logic [IDX_W-1:0] ridx,
  output logic             r_valid,
  output logic             r_dirty,
  output logic [TAG_W-1:0] r_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (clr_all) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (we) begin
      valid_q[widx] <= wvalid;
      dirty_q[widx] <= wdirty;
    end
  end

  always_ff @(posedge clk) begin
    if (we) tag_q[widx] <= wtag;
  end

  assign r_valid = valid_q[ridx];
  assign r_dirty = dirty_q[ridx];
  assign r_tag   = tag_q[ridx];

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line_chk
      // R1: a modified line is always a valid line
      a_r1_dirty_needs_valid: assert property (@(posedge clk) disable iff (rst)
        dirty_q[i] |-> valid_q[i]);
    end
  endgenerate

  // R1: invalidate-all leaves no valid line behind
  a_r1_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (valid_q == '0) && (dirty_q == '0));
endmodule

// File: rtl/dc_data_ram.sv
module dc_data_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dc_push_buf.sv
module dc_push_buf #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int WW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [WW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [WW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot [WORDS];

  always_ff @(posedge clk) begin
    if (we) slot[widx] <= wdata;
  end

  assign rdata = slot[ridx];
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [1:0]        cpu_req_op,
  input  logic              cpu_req_we,
  input  logic              cpu_req_wt,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WRD_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - WRD_W;
  localparam int RAM_AW = IDX_W + WRD_W;
  localparam int CNT_W  = WRD_W + 1;

  dc_state_e           state_q;
  dc_op_e              op_q;
  logic                we_q, wt_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                push_pend_q;
  logic [TAG_W-1:0]    vtag_q;
  logic                rsp_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                mreq_v_q, mreq_we_q;
  logic [ADDR_W-1:0]   maddr_q;
  logic [DATA_W-1:0]   mwdata_q;

  logic [TAG_W-1:0]    q_tag;
  logic [IDX_W-1:0]    q_idx, in_idx;
  logic [WRD_W-1:0]    q_wrd, in_wrd, cnt_w;
  dc_op_e              in_op;
  logic                accept;

  assign q_tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign q_idx  = addr_q[WRD_W +: IDX_W];
  assign q_wrd  = addr_q[WRD_W-1:0];
  assign in_idx = cpu_req_addr[WRD_W +: IDX_W];
  assign in_wrd = cpu_req_addr[WRD_W-1:0];
  assign cnt_w  = cnt_q[WRD_W-1:0];
  assign in_op  = dc_op_e'(cpu_req_op);
  assign accept = cpu_req_valid && (state_q == ST_IDLE);

  function automatic logic [ADDR_W-1:0] word_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic [WRD_W-1:0] w);
    return {t, i, w};
  endfunction

  // line state lookup
  logic             lk_valid, lk_dirty, lk_hit;
  logic [TAG_W-1:0] lk_tag;
  logic             tag_we, tag_wvalid, tag_wdirty, clr_all;
  logic [TAG_W-1:0] tag_wtag;

  dc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .clr_all(clr_all),
    .we(tag_we), .widx(q_idx), .wtag(tag_wtag),
    .wvalid(tag_wvalid), .wdirty(tag_wdirty),
    .ridx(q_idx), .r_valid(lk_valid), .r_dirty(lk_dirty), .r_tag(lk_tag)
  );

  assign lk_hit = lk_valid && (lk_tag == q_tag);

  // data storage
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  dc_data_ram #(.DEPTH(LINES*WORDS), .DW(DATA_W)) u_data (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  // victim buffer
  logic              pb_we;
  logic [WRD_W-1:0]  pb_widx, pb_ridx;
  logic [DATA_W-1:0] pb_rdata;

  dc_push_buf #(.WORDS(WORDS), .DW(DATA_W)) u_push (
    .clk(clk), .we(pb_we), .widx(pb_widx), .wdata(ram_rdata),
    .ridx(pb_ridx), .rdata(pb_rdata)
  );

  assign pb_we   = (state_q == ST_PUSH) && (cnt_q != '0);
  assign pb_widx = cnt_w - WRD_W'(1);
  assign pb_ridx = (state_q == ST_DRAIN) ? cnt_w + WRD_W'(1) : '0;

  always_comb begin
    case (state_q)
      ST_IDLE: ram_raddr = {in_idx, in_wrd};
      ST_PUSH: ram_raddr = {q_idx, cnt_w};
      default: ram_raddr = {q_idx, q_wrd};
    endcase
  end

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {q_idx, q_wrd};
    ram_wdata = wdata_q;
    if (state_q == ST_LOOK && op_q == OP_ACCESS && we_q && lk_hit) begin
      ram_we = 1'b1;
    end else if (state_q == ST_FILL && mem_ack) begin
      ram_we    = 1'b1;
      ram_waddr = {q_idx, cnt_w};
      ram_wdata = (we_q && cnt_w == q_wrd) ? wdata_q : mem_rdata;
    end
  end

  always_comb begin
    tag_we     = 1'b0;
    tag_wtag   = q_tag;
    tag_wvalid = 1'b1;
    tag_wdirty = 1'b0;
    clr_all    = accept && (in_op == OP_INV_ALL);
    case (state_q)
      ST_LOOK: begin
        if (op_q == OP_ACCESS && we_q && lk_hit && !(wt_q && !lk_dirty)) begin
          tag_we     = 1'b1;
          tag_wdirty = 1'b1;
        end
      end
      ST_PUSH: begin
        if (cnt_q == CNT_W'(WORDS) && op_q == OP_PUSH) begin
          tag_we   = 1'b1;
          tag_wtag = lk_tag;
        end
      end
      ST_FILL: begin
        if (mem_ack && cnt_w == WRD_W'(WORDS-1)) begin
          tag_we     = 1'b1;
          tag_wdirty = we_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_ACCESS;
      we_q        <= 1'b0;
      wt_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      cnt_q       <= '0;
      push_pend_q <= 1'b0;
      vtag_q      <= '0;
      rsp_q       <= 1'b0;
      rdata_q     <= '0;
      mreq_v_q    <= 1'b0;
      mreq_we_q   <= 1'b0;
      maddr_q     <= '0;
      mwdata_q    <= '0;
    end else begin
      rsp_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= in_op;
            we_q    <= cpu_req_we;
            wt_q    <= cpu_req_wt;
            addr_q  <= cpu_req_addr;
            wdata_q <= cpu_req_wdata;
            if (in_op == OP_ACCESS || in_op == OP_PUSH) state_q <= ST_LOOK;
            else rsp_q <= 1'b1;
          end
        end
        ST_LOOK: begin
          cnt_q <= '0;
          if (op_q == OP_PUSH) begin
            if (lk_valid && lk_dirty) state_q <= ST_PUSH;
            else begin
              rsp_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (!we_q && lk_hit) begin
            rdata_q <= ram_rdata;
            rsp_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (we_q && lk_hit && !(wt_q && !lk_dirty)) begin
            rsp_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (we_q && wt_q) begin
            mreq_v_q  <= 1'b1;
            mreq_we_q <= 1'b1;
            maddr_q   <= addr_q;
            mwdata_q  <= wdata_q;
            state_q   <= ST_WT;
          end else if (lk_valid && lk_dirty) begin
            state_q <= ST_PUSH;
          end else begin
            mreq_v_q  <= 1'b1;
            mreq_we_q <= 1'b0;
            maddr_q   <= word_addr(q_tag, q_idx, '0);
            state_q   <= ST_FILL;
          end
        end
        ST_PUSH: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(WORDS)) begin
            cnt_q       <= '0;
            vtag_q      <= lk_tag;
            push_pend_q <= 1'b1;
            mreq_v_q    <= 1'b1;
            if (op_q == OP_PUSH) begin
              mreq_we_q <= 1'b1;
              maddr_q   <= word_addr(lk_tag, q_idx, '0);
              mwdata_q  <= pb_rdata;
              state_q   <= ST_DRAIN;
            end else begin
              mreq_we_q <= 1'b0;
              maddr_q   <= word_addr(q_tag, q_idx, '0);
              state_q   <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (!we_q && cnt_w == q_wrd) rdata_q <= mem_rdata;
            if (cnt_w == WRD_W'(WORDS-1)) begin
              cnt_q <= '0;
              rsp_q <= 1'b1;
              if (push_pend_q) begin
                mreq_we_q <= 1'b1;
                maddr_q   <= word_addr(vtag_q, q_idx, '0);
                mwdata_q  <= pb_rdata;
                state_q   <= ST_DRAIN;
              end else begin
                mreq_v_q <= 1'b0;
                state_q  <= ST_IDLE;
              end
            end else begin
              maddr_q <= word_addr(q_tag, q_idx, cnt_w + WRD_W'(1));
            end
          end
        end
        ST_WT: begin
          if (mem_ack) begin
            mreq_v_q <= 1'b0;
            rsp_q    <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        ST_DRAIN: begin
          if (mem_ack) begin
            if (cnt_w == WRD_W'(WORDS-1)) begin
              cnt_q       <= '0;
              mreq_v_q    <= 1'b0;
              push_pend_q <= 1'b0;
              state_q     <= ST_IDLE;
              if (op_q == OP_PUSH) rsp_q <= 1'b1;
            end else begin
              cnt_q    <= cnt_q + CNT_W'(1);
              maddr_q  <= word_addr(vtag_q, q_idx, cnt_w + WRD_W'(1));
              mwdata_q <= pb_rdata;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = rsp_q;
  assign cpu_rsp_rdata = rdata_q;
  assign mem_req_valid = mreq_v_q;
  assign mem_req_we    = mreq_we_q;
  assign mem_req_addr  = maddr_q;
  assign mem_req_wdata = mwdata_q;

  // R11: a pending memory beat does not change until acknowledged
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_ack |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R10: a write-through access only writes a modified mark onto a line already modified
  a_r10_wt_no_new_dirty: assert property (@(posedge clk) disable iff (rst)
    tag_we && tag_wdirty && wt_q |-> lk_hit && lk_dirty);

  // R8: the CPU is answered in the cycle the victim drain begins
  a_r8_serve_before_drain: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_DRAIN) && op_q == OP_ACCESS |-> cpu_rsp_valid);

  // R12: no memory beat is outstanding while idle
  a_r12_idle_no_mem: assert property (@(posedge clk) disable iff (rst)
    cpu_req_ready |-> !mem_req_valid);
endmodule

// File: tb/dcache_ctrl_test.sv
`timescale 1ns/1ps
module dcache_ctrl_test;
  localparam int K_RD = 0, K_WR = 1, K_RSP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic [1:0]  cpu_req_op = 2'd0;
  logic        cpu_req_we = 1'b0;
  logic        cpu_req_wt = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  dcache_ctrl uut (.*);

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [31:0] data;
    logic        chk;
    logic [7:0]  rid;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] mm [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];
  bit          bm_v [8];
  bit          bm_d [8];
  logic [26:0] bm_t [8];
  logic [31:0] bm_w [8][4];

  function automatic logic [31:0] seed_val(input logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] mm_rd(input logic [31:0] a);
    return mm.exists(a) ? mm[a] : seed_val(a);
  endfunction
  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_val(a);
  endfunction

  task automatic push_exp(input int kind, input logic [31:0] a, input logic [31:0] d,
                          input bit chk, input int rid);
    exp_t e;
    e.kind = 2'(kind); e.addr = a; e.data = d; e.chk = chk; e.rid = 8'(rid);
    exp_q.push_back(e);
  endtask

  task automatic pop_check(input int kind, input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R12 unexpected event kind=%0d addr=%h data=%h, expected none", kind, a, d);
      return;
    end
    e = exp_q.pop_front();
    if (e.kind != 2'(kind) || (kind != K_RSP && e.addr != a) || (kind == K_WR && e.data != d)
        || (kind == K_RSP && e.chk && e.data != d)) begin
      errors++;
      $display("FAIL R%0d actual kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
               e.rid, kind, a, d, e.kind, e.addr, e.data);
    end
  endtask

  // reference line-state model built from the requirements
  task automatic model(input int op, input bit we, input bit wt, input logic [31:0] a,
                       input logic [31:0] wd, input int rid);
    int idx = int'(a[4:2]);
    int w   = int'(a[1:0]);
    logic [26:0] tg = a[31:5];
    bit hit = bm_v[idx] && bm_t[idx] == tg;
    logic [31:0] vic [4];
    bit vdirty;
    logic [31:0] fa, va;
    if (op == 1) begin            // R1
      push_exp(K_RSP, 0, 0, 0, rid);
      for (int i = 0; i < 8; i++) begin bm_v[i] = 0; bm_d[i] = 0; end
      return;
    end
    if (op == 2) begin            // R9
      if (bm_v[idx] && bm_d[idx]) begin
        for (int k = 0; k < 4; k++) begin
          va = {bm_t[idx], 3'(idx), 2'(k)};
          push_exp(K_WR, va, bm_w[idx][k], 1, rid);
          ref_mem[va] = bm_w[idx][k];
        end
        bm_d[idx] = 0;
      end
      push_exp(K_RSP, 0, 0, 0, rid);
      return;
    end
    if (op == 3) begin push_exp(K_RSP, 0, 0, 0, rid); return; end
    if (!we && hit) begin         // R3
      push_exp(K_RSP, 0, bm_w[idx][w], 1, rid);
      return;
    end
    if (we && hit) begin
      bm_w[idx][w] = wd;
      if (wt && !bm_d[idx]) begin // R7
        push_exp(K_WR, a, wd, 1, rid);
        ref_mem[a] = wd;
      end else bm_d[idx] = 1;     // R6, R10
      push_exp(K_RSP, 0, 0, 0, rid);
      return;
    end
    if (we && wt) begin           // R5
      push_exp(K_WR, a, wd, 1, rid);
      ref_mem[a] = wd;
      push_exp(K_RSP, 0, 0, 0, rid);
      return;
    end
    vdirty = bm_v[idx] && bm_d[idx];   // R8
    for (int k = 0; k < 4; k++) vic[k] = bm_w[idx][k];
    va = {bm_t[idx], 3'(idx), 2'b00};
    for (int k = 0; k < 4; k++) begin  // R2, R4
      fa = {tg, 3'(idx), 2'(k)};
      push_exp(K_RD, fa, 0, 0, rid);
      bm_w[idx][k] = (we && k == w) ? wd : ref_rd(fa);
    end
    push_exp(K_RSP, 0, bm_w[idx][w], !we, rid);
    if (vdirty) begin
      for (int k = 0; k < 4; k++) begin
        push_exp(K_WR, {va[31:2], 2'(k)}, vic[k], 1, 8);
        ref_mem[{va[31:2], 2'(k)}] = vic[k];
      end
    end
    bm_v[idx] = 1; bm_t[idx] = tg; bm_d[idx] = we;
  endtask

  task automatic do_req(input int op, input bit we, input bit wt, input logic [31:0] a,
                        input logic [31:0] wd, input int rid);
    model(op, we, wt, a, wd, rid);
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1; cpu_req_op = 2'(op); cpu_req_we = we; cpu_req_wt = wt;
    cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 0;
    while (exp_q.size() != 0 || !cpu_req_ready) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input int tg, input int idx, input int w);
    return {27'(tg), 3'(idx), 2'(w)};
  endfunction

  // scoreboard monitor and memory responder
  int wcnt = 0, dly = 1;
  logic [31:0] seen_addr = '0;
  logic [7:0]  dl = 8'h5B;
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 0; wcnt = 0;
    end else begin
      if (cpu_rsp_valid) pop_check(K_RSP, 0, cpu_rsp_rdata);
      if (mem_ack) mem_ack = 0;
      else if (mem_req_valid) begin
        if (wcnt == 0) seen_addr = mem_req_addr;
        wcnt++;
        if (wcnt >= dly) begin
          checks++;
          if (seen_addr !== mem_req_addr) begin
            errors++;
            $display("FAIL R11 beat address moved: actual %h expected %h", mem_req_addr, seen_addr);
          end
          if (mem_req_we) begin
            pop_check(K_WR, mem_req_addr, mem_req_wdata);
            mm[mem_req_addr] = mem_req_wdata;
          end else begin
            pop_check(K_RD, mem_req_addr, 0);
            mem_rdata = mm_rd(mem_req_addr);
          end
          mem_ack = 1; wcnt = 0;
          dl = {dl[6:0], dl[7] ^ dl[5] ^ dl[4] ^ dl[3]};
          dly = 1 + int'(dl % 3);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog expired: actual hung, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r = 32'hC0FF_EE11;
    for (int i = 0; i < 8; i++) begin bm_v[i] = 0; bm_d[i] = 0; bm_t[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 / R1: reset state at the ports
    checks++;
    if (cpu_req_ready !== 1'b1 || cpu_rsp_valid !== 1'b0 || mem_req_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: actual ready=%b rsp=%b mreq=%b expected 1 0 0",
               cpu_req_ready, cpu_rsp_valid, mem_req_valid);
    end
    do_req(0, 0, 0, mk(1, 1, 2), 0, 2);          // R2 read miss
    do_req(0, 0, 0, mk(1, 1, 0), 0, 3);          // R3 read hit
    do_req(0, 1, 0, mk(1, 1, 3), 32'hAAAA_0001, 6); // R6 copy-back hit
    do_req(0, 0, 0, mk(1, 1, 3), 0, 3);          // R3 hit on modified line
    do_req(0, 0, 0, mk(2, 1, 1), 0, 8);          // R8 miss on modified line
    do_req(0, 1, 1, mk(1, 2, 0), 32'hBBBB_0002, 5); // R5 write-through miss
    do_req(0, 0, 0, mk(1, 2, 0), 0, 5);          // R5 no allocation: fill
    do_req(0, 1, 1, mk(1, 2, 1), 32'hCCCC_0003, 7); // R7 write-through hit
    do_req(0, 0, 0, mk(1, 2, 1), 0, 7);          // R7 cache updated
    do_req(0, 0, 0, mk(3, 2, 0), 0, 7);          // R7 eviction without write-back
    do_req(0, 1, 0, mk(1, 3, 2), 32'hDDDD_0004, 4); // R4 allocate and merge
    do_req(0, 1, 0, mk(2, 3, 0), 32'hDDDD_0005, 4); // R4 merged data written back
    do_req(2, 0, 0, mk(0, 3, 0), 0, 9);          // R9 push modified line
    do_req(0, 0, 0, mk(2, 3, 0), 0, 9);          // R9 still valid: hit
    do_req(2, 0, 0, mk(0, 3, 0), 0, 9);          // R9 clean line: no traffic
    do_req(2, 0, 0, mk(0, 5, 0), 0, 9);          // R9 invalid line: no traffic
    do_req(0, 1, 0, mk(1, 4, 0), 32'hEEEE_0006, 10); // make line 4 modified
    do_req(0, 1, 1, mk(1, 4, 1), 32'hEEEE_0007, 10); // R10 write-through on modified
    do_req(0, 0, 0, mk(1, 4, 1), 0, 10);         // R10 reads back the new word
    do_req(1, 0, 0, 0, 0, 1);                    // R1 invalidate with dirty lines
    do_req(0, 0, 0, mk(1, 4, 0), 0, 1);          // R1 old memory value returns
    for (int n = 0; n < 120; n++) begin          // R12 mixed traffic
      r = r * 32'd1664525 + 32'd1013904223;
      if (r[31:27] == 0) do_req(1, 0, 0, 0, 0, 12);
      else if (r[31:28] == 1) do_req(2, 0, 0, mk(0, int'(r[6:4]), 0), 0, 12);
      else do_req(0, r[10], r[11], mk(int'(r[9:8]) % 3, int'(r[6:4]), int'(r[3:2])), r ^ 32'h1357_9BDF, 12);
    end
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || mem_req_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12 leftover: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule